// File: doc/BRIEF.md
# Power-Down Entry and Wake-Up Controller

This block decides when a small microcontroller core stops its high-frequency clock and how it comes back. A one-cycle request from the core (the write to the power-down control bit) moves the controller into power-down, unless the watchdog is enabled. While powered down, the high-frequency oscillator halt output is high, and the 32 kHz oscillator halt output follows the keep-running bit as it stood at entry.

Power-down ends in one of two ways. An external reset returns the controller to the run state and clears all of its state. A qualifying external or seconds interrupt also ends it, and in that case the rest of the chip keeps its state. If an interrupt of equal or higher priority is already in service, the controller parks in idle until a strictly higher-priority request arrives. Otherwise it waits for the clock-stable acknowledgement from the start-up sequencer, then raises a one-cycle resume pulse. The core resumes at the instruction that follows the power-down write.

Top module: `pwk_ctrl`

## Requirements
- R1: With `wdt_on` low and `ext_rst` low, a `pd_req` pulse in the run state enters power-down at the next edge. `hf_halt` is high exactly while in power-down.
- R2: While `wdt_on` is high, `pd_req` is ignored: `hf_halt`, `osc32_halt` and `idle_o` stay low.
- R3: Power-down is left only on `ext_rst` or a qualified wake. Any other input activity keeps `hf_halt` high.
- R4: An external line (`int0_n`, `int1_n`, active low) qualifies as a wake only when its enable bit is 1, its mode bit is 1 (1 means level-sensitive, 0 means edge) and the line is low.
- R5: `sec_req` qualifies as a wake only when `sec_en` is 1, `int1_en` is 1 and `int1_lvl` is 1.
- R6: On a qualified wake, let P be the highest priority among the qualified sources. The seconds source uses `int1_prio`. If `srv_active` is high and `srv_prio` is at least P, the next state is idle (`idle_o` high, both halts low). Otherwise the next state is the wait state (all four outputs low).
- R7: Idle is left for the wait state only when an enabled request is pending and either `srv_active` is low or the request's priority is strictly above `srv_prio`. A request is pending when its line is low, in either mode, or when the seconds request is enabled. Otherwise idle holds.
- R8: On entering power-down, `osc32_halt` becomes the inverse of `run32`. It is low in every other state.
- R9: In the wait state, `clk_stable` high moves the controller to run and gives `resume` high for exactly one cycle. If the wait state was entered from power-down and the wake qualification drops before `clk_stable`, the controller returns to power-down.
- R10: `ext_rst` high forces the run state at the next edge from any state, with all outputs low and no `resume` pulse. It overrides any wake and any `pd_req`.
- R11: After the asynchronous `rst_n` is released, the controller is in the run state with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_rst | input | 1 | External reset pin, synchronous, active high |
| pd_req | input | 1 | One-cycle power-down request from the core |
| wdt_on | input | 1 | Watchdog enabled |
| run32 | input | 1 | Keep the 32 kHz oscillator running in power-down |
| int0_n | input | 1 | External request line 0, active low |
| int1_n | input | 1 | External request line 1, active low |
| int0_lvl | input | 1 | Line 0 mode, 1 = level-sensitive |
| int1_lvl | input | 1 | Line 1 mode, 1 = level-sensitive |
| int0_en | input | 1 | Line 0 enable |
| int1_en | input | 1 | Line 1 enable |
| sec_req | input | 1 | Seconds-timer request flag |
| sec_en | input | 1 | Seconds request enable |
| int0_prio | input | PRIO_W | Priority of line 0 |
| int1_prio | input | PRIO_W | Priority of line 1 and the seconds source |
| srv_active | input | 1 | An interrupt is in service |
| srv_prio | input | PRIO_W | Priority of the interrupt in service |
| clk_stable | input | 1 | Clock-stable acknowledgement from the start-up sequencer |
| hf_halt | output | 1 | Stop the high-frequency oscillator |
| osc32_halt | output | 1 | Stop the 32 kHz oscillator |
| idle_o | output | 1 | Controller is parked in idle |
| resume | output | 1 | One-cycle pulse: core returns to run |

## Verification
The bench builds the block with `PRIO_W` = 2, which gives four priority levels. With four levels, the same test can place the in-service priority equal to, below, and above a wake source, so both sides of the idle decision and the strict comparison for leaving idle are all exercised. The same default width lets two wake sources carry different priorities at once, which checks that the higher one decides.

// File: rtl/pwk_pkg.sv
package pwk_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_IDLE = 2'd1,
        ST_PD   = 2'd2,
        ST_WAIT = 2'd3
    } pwk_state_e;

    typedef struct packed {
        pwk_state_e st;
        logic       from_pd;
        logic       o32_halt;
        logic       resume;
    } pwk_regs_t;
endpackage

// File: rtl/pwk_wake_qual.sv
module pwk_wake_qual #(
    parameter int PRIO_W = 2
) (
    input  logic              int0_n,
    input  logic              int1_n,
    input  logic              int0_lvl,
    input  logic              int1_lvl,
    input  logic              int0_en,
    input  logic              int1_en,
    input  logic              sec_req,
    input  logic              sec_en,
    input  logic [PRIO_W-1:0] int0_prio,
    input  logic [PRIO_W-1:0] int1_prio,
    output logic              wake_hit,
    output logic [PRIO_W-1:0] wake_prio,
    output logic              req_any,
    output logic [PRIO_W-1:0] req_prio
);
    localparam int NSRC = 2;

    logic [NSRC-1:0]        wq;
    logic [NSRC-1:0]        rq;
    logic [PRIO_W-1:0]      pr [NSRC];

    // Source 0: line 0; source 1: line 1 merged with the seconds request.
    assign wq[0] = int0_en & int0_lvl & ~int0_n;
    assign wq[1] = int1_en & int1_lvl & (~int1_n | (sec_en & sec_req));
    assign rq[0] = int0_en & ~int0_n;
    assign rq[1] = int1_en & (~int1_n | (sec_en & sec_req));
    assign pr[0] = int0_prio;
    assign pr[1] = int1_prio;

    always_comb begin
        wake_prio = '0;
        req_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (wq[i] && pr[i] > wake_prio) wake_prio = pr[i];
            if (rq[i] && pr[i] > req_prio)  req_prio  = pr[i];
        end
    end

    assign wake_hit = |wq;
    assign req_any  = |rq;
endmodule

// File: rtl/pwk_prio_gate.sv
module pwk_prio_gate #(
    parameter int PRIO_W = 2
) (
    input  logic              srv_active,
    input  logic [PRIO_W-1:0] srv_prio,
    input  logic [PRIO_W-1:0] wake_prio,
    input  logic              req_any,
    input  logic [PRIO_W-1:0] req_prio,
    output logic              park_idle,
    output logic              leave_idle
);
    assign park_idle  = srv_active && (srv_prio >= wake_prio);
    assign leave_idle = req_any && (!srv_active || (req_prio > srv_prio));
endmodule

// File: rtl/pwk_fsm.sv
module pwk_fsm
    import pwk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst,
    input  logic       pd_req,
    input  logic       wdt_on,
    input  logic       run32,
    input  logic       wake_hit,
    input  logic       park_idle,
    input  logic       leave_idle,
    input  logic       clk_stable,
    output pwk_state_e st,
    output logic       hf_halt,
    output logic       osc32_halt,
    output logic       idle_o,
    output logic       resume
);
    pwk_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.resume = 1'b0;
        if (ext_rst) begin
            r_d = '{st: ST_RUN, from_pd: 1'b0, o32_halt: 1'b0, resume: 1'b0};
        end else begin
            case (r_q.st)
                ST_RUN: begin
                    if (pd_req && !wdt_on) begin
                        r_d.st       = ST_PD;
                        r_d.o32_halt = ~run32;
                    end
                end
                ST_PD: begin
                    if (wake_hit) begin
                        r_d.o32_halt = 1'b0;
                        r_d.from_pd  = !park_idle;
                        r_d.st       = park_idle ? ST_IDLE : ST_WAIT;
                    end
                end
                ST_IDLE: begin
                    if (leave_idle) begin
                        r_d.st      = ST_WAIT;
                        r_d.from_pd = 1'b0;
                    end
                end
                default: begin
                    if (clk_stable) begin
                        r_d.st      = ST_RUN;
                        r_d.resume  = 1'b1;
                        r_d.from_pd = 1'b0;
                    end else if (r_q.from_pd && !wake_hit) begin
                        r_d.st       = ST_PD;
                        r_d.o32_halt = ~run32;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_RUN, from_pd: 1'b0, o32_halt: 1'b0, resume: 1'b0};
        else        r_q <= r_d;
    end

    assign st         = r_q.st;
    assign hf_halt    = (r_q.st == ST_PD);
    assign idle_o     = (r_q.st == ST_IDLE);
    assign osc32_halt = r_q.o32_halt;
    assign resume     = r_q.resume;
endmodule

// File: rtl/pwk_ctrl.sv
module pwk_ctrl
    import pwk_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst,
    input  logic              pd_req,
    input  logic              wdt_on,
    input  logic              run32,
    input  logic              int0_n,
    input  logic              int1_n,
    input  logic              int0_lvl,
    input  logic              int1_lvl,
    input  logic              int0_en,
    input  logic              int1_en,
    input  logic              sec_req,
    input  logic              sec_en,
    input  logic [PRIO_W-1:0] int0_prio,
    input  logic [PRIO_W-1:0] int1_prio,
    input  logic              srv_active,
    input  logic [PRIO_W-1:0] srv_prio,
    input  logic              clk_stable,
    output logic              hf_halt,
    output logic              osc32_halt,
    output logic              idle_o,
    output logic              resume
);
    logic              wake_hit;
    logic [PRIO_W-1:0] wake_prio;
    logic              req_any;
    logic [PRIO_W-1:0] req_prio;
    logic              park_idle;
    logic              leave_idle;
    pwk_state_e        st;

    pwk_wake_qual #(.PRIO_W(PRIO_W)) u_qual (
        .int0_n(int0_n), .int1_n(int1_n),
        .int0_lvl(int0_lvl), .int1_lvl(int1_lvl),
        .int0_en(int0_en), .int1_en(int1_en),
        .sec_req(sec_req), .sec_en(sec_en),
        .int0_prio(int0_prio), .int1_prio(int1_prio),
        .wake_hit(wake_hit), .wake_prio(wake_prio),
        .req_any(req_any), .req_prio(req_prio)
    );

    pwk_prio_gate #(.PRIO_W(PRIO_W)) u_gate (
        .srv_active(srv_active), .srv_prio(srv_prio),
        .wake_prio(wake_prio), .req_any(req_any), .req_prio(req_prio),
        .park_idle(park_idle), .leave_idle(leave_idle)
    );

    pwk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst),
        .pd_req(pd_req), .wdt_on(wdt_on), .run32(run32),
        .wake_hit(wake_hit), .park_idle(park_idle), .leave_idle(leave_idle),
        .clk_stable(clk_stable), .st(st),
        .hf_halt(hf_halt), .osc32_halt(osc32_halt),
        .idle_o(idle_o), .resume(resume)
    );
endmodule

// File: rtl/pwk_ctrl_chk.sv
module pwk_ctrl_chk
    import pwk_pkg::*;
#(
    parameter int PRIO_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_rst,
    input logic              pd_req,
    input logic              wdt_on,
    input logic              run32,
    input logic              srv_active,
    input logic [PRIO_W-1:0] srv_prio,
    input logic              wake_hit,
    input logic [PRIO_W-1:0] wake_prio,
    input logic [1:0]        st,
    input logic              hf_halt,
    input logic              osc32_halt,
    input logic              idle_o,
    input logic              resume
);
    p_enter_pd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && pd_req && !wdt_on && !ext_rst) |=> hf_halt);

    p_wdt_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && pd_req && wdt_on && !ext_rst) |=> (!hf_halt && !idle_o));

    p_pd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PD && !wake_hit && !ext_rst) |=> hf_halt);

    p_park_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PD && wake_hit && srv_active && srv_prio >= wake_prio && !ext_rst)
        |=> (idle_o && !hf_halt));

    p_osc32_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && pd_req && !wdt_on && !ext_rst) |=> (osc32_halt == !$past(run32)));

    p_resume_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !resume);

    p_ext_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst |=> (st == ST_RUN && !resume && !osc32_halt));
endmodule

bind pwk_ctrl pwk_ctrl_chk #(.PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/pwk_ctrl_tb.sv
`timescale 1ns/1ps
module pwk_ctrl_tb;
    localparam int PW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst = 0, pd_req = 0, wdt_on = 0, run32 = 0;
    logic int0_n = 1, int1_n = 1, int0_lvl = 0, int1_lvl = 0;
    logic int0_en = 0, int1_en = 0, sec_req = 0, sec_en = 0;
    logic [PW-1:0] int0_prio = '0, int1_prio = '0, srv_prio = '0;
    logic srv_active = 0, clk_stable = 0;
    logic hf_halt, osc32_halt, idle_o, resume;

    always #2.5 clk = ~clk;

    pwk_ctrl #(.PRIO_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_rst(ext_rst), .pd_req(pd_req),
        .wdt_on(wdt_on), .run32(run32), .int0_n(int0_n), .int1_n(int1_n),
        .int0_lvl(int0_lvl), .int1_lvl(int1_lvl), .int0_en(int0_en),
        .int1_en(int1_en), .sec_req(sec_req), .sec_en(sec_en),
        .int0_prio(int0_prio), .int1_prio(int1_prio),
        .srv_active(srv_active), .srv_prio(srv_prio), .clk_stable(clk_stable),
        .hf_halt(hf_halt), .osc32_halt(osc32_halt), .idle_o(idle_o), .resume(resume)
    );

    typedef struct {
        logic  hf;
        logic  o32;
        logic  idl;
        logic  res;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // Monitor: one expected item per clock edge, compared just after the edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if ({hf_halt, osc32_halt, idle_o, resume} !== {e.hf, e.o32, e.idl, e.res}) begin
                bad++;
                $display("FAIL %s: got hf/o32/idle/res=%b%b%b%b expected %b%b%b%b",
                         e.tag, hf_halt, osc32_halt, idle_o, resume,
                         e.hf, e.o32, e.idl, e.res);
            end
        end
    end

    // Driver: push the expectation for the coming edge, then advance one cycle.
    task automatic cyc(input logic hf, input logic o32, input logic idl,
                       input logic res, input string tag);
        exp_t e;
        e.hf = hf; e.o32 = o32; e.idl = idl; e.res = res; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic quiet();
        pd_req = 0; wdt_on = 0; ext_rst = 0; run32 = 0;
        int0_n = 1; int1_n = 1; int0_lvl = 0; int1_lvl = 0;
        int0_en = 0; int1_en = 0; sec_req = 0; sec_en = 0;
        int0_prio = '0; int1_prio = '0; srv_active = 0; srv_prio = '0;
        clk_stable = 0;
    endtask

    task automatic go_pd(input logic keep32, input string tag);
        run32 = keep32; pd_req = 1;
        cyc(1, ~keep32, 0, 0, tag);
        pd_req = 0;
    endtask

    task automatic finish_run();
        @(posedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (4000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc(0, 0, 0, 0, "R11 state after reset");

        // R1 / R8: entry with 32 kHz halted
        go_pd(0, "R1 R8 enter power-down, 32k halted");
        cyc(1, 1, 0, 0, "R3 stays in power-down");

        // R4: edge mode, disabled, wrong line do not wake
        int0_n = 0; int0_en = 1; int0_lvl = 0;
        cyc(1, 1, 0, 0, "R4 edge-mode line 0 no wake");
        int0_lvl = 1; int0_en = 0;
        cyc(1, 1, 0, 0, "R4 disabled line 0 no wake");
        int0_en = 1; int0_n = 1; pd_req = 1;
        cyc(1, 1, 0, 0, "R3 pd_req in power-down no effect");
        pd_req = 0; int1_n = 0; int1_en = 1; int1_lvl = 0;
        cyc(1, 1, 0, 0, "R4 edge-mode line 1 no wake");
        int1_n = 1; int1_en = 0;

        // R4 / R9: level wake, release before stable, re-wake, stable
        int0_n = 0;
        cyc(0, 0, 0, 0, "R4 level line 0 wakes to wait");
        int0_n = 1;
        cyc(1, 1, 0, 0, "R9 released before stable returns to power-down");
        int0_n = 0;
        cyc(0, 0, 0, 0, "R9 re-wake to wait");
        cyc(0, 0, 0, 0, "R9 wait holds without clk_stable");
        clk_stable = 1;
        cyc(0, 0, 0, 1, "R9 resume pulse");
        clk_stable = 0;
        cyc(0, 0, 0, 0, "R9 resume lasts one cycle");
        quiet();

        // R2: watchdog blocks entry
        wdt_on = 1; pd_req = 1;
        cyc(0, 0, 0, 0, "R2 watchdog blocks power-down");
        pd_req = 0;
        cyc(0, 0, 0, 0, "R2 still running");
        quiet();

        // R8: 32 kHz kept running
        go_pd(1, "R8 enter power-down, 32k running");
        run32 = 0;
        cyc(1, 0, 0, 0, "R8 osc32 halt follows value at entry");

        // R5: seconds request
        sec_req = 1; sec_en = 1; int1_en = 1; int1_lvl = 0;
        cyc(1, 0, 0, 0, "R5 seconds with line 1 edge mode no wake");
        int1_lvl = 1; sec_en = 0;
        cyc(1, 0, 0, 0, "R5 seconds disabled no wake");
        sec_en = 1;
        cyc(0, 0, 0, 0, "R5 seconds wake");
        clk_stable = 1;
        cyc(0, 0, 0, 1, "R5 R9 resume after seconds wake");
        quiet();

        // R6 / R7: equal in-service priority parks in idle
        go_pd(0, "R1 enter power-down for idle test");
        srv_active = 1; srv_prio = 2'd2;
        int0_en = 1; int0_lvl = 1; int0_prio = 2'd2; int0_n = 0;
        cyc(0, 0, 1, 0, "R6 equal priority parks in idle");
        cyc(0, 0, 1, 0, "R7 idle holds with equal priority request");
        int1_en = 1; int1_prio = 2'd3; int1_n = 0; clk_stable = 1;
        cyc(0, 0, 0, 0, "R7 higher priority leaves idle");
        cyc(0, 0, 0, 1, "R7 R9 resume after idle");
        quiet();

        // R6: lower in-service priority goes straight to wait
        go_pd(0, "R1 enter power-down for lower priority test");
        srv_active = 1; srv_prio = 2'd1;
        int0_en = 1; int0_lvl = 1; int0_prio = 2'd2; int0_n = 0;
        cyc(0, 0, 0, 0, "R6 lower in-service priority wakes to wait");
        clk_stable = 1;
        cyc(0, 0, 0, 1, "R6 resume");
        quiet();

        // R6: highest of two sources decides
        go_pd(0, "R1 enter power-down for two-source test");
        srv_active = 1; srv_prio = 2'd2;
        int0_en = 1; int0_lvl = 1; int0_prio = 2'd1; int0_n = 0;
        int1_en = 1; int1_lvl = 1; int1_prio = 2'd3; int1_n = 0;
        cyc(0, 0, 0, 0, "R6 higher of two wake sources wins");
        quiet();
        cyc(1, 1, 0, 0, "R9 both released returns to power-down");

        // R10: external reset overrides a wake and a request
        int0_en = 1; int0_lvl = 1; int0_n = 0; ext_rst = 1;
        srv_active = 1; srv_prio = 2'd3;
        cyc(0, 0, 0, 0, "R10 reset wins over wake");
        quiet();
        ext_rst = 1; pd_req = 1;
        cyc(0, 0, 0, 0, "R10 reset wins over pd_req");
        quiet();
        go_pd(0, "R1 enter power-down before idle reset");
        srv_active = 1; srv_prio = 2'd3;
        int0_en = 1; int0_lvl = 1; int0_n = 0;
        cyc(0, 0, 1, 0, "R6 park idle before reset");
        ext_rst = 1;
        cyc(0, 0, 0, 0, "R10 reset leaves idle without resume");
        quiet();
        cyc(0, 0, 0, 0, "R10 stays in run after reset");

        done = 1;
        finish_run();
    end
endmodule